// File: doc/BRIEF.md
# Boot-Overlay Bus Glue Controller

This block is the address decode and bus-cycle termination glue for a small processor system with a 20-bit address bus and byte-wide data. The two top address bits split the space into four equal 256 KB regions: RAM, ROM, fast I/O and slow I/O. For each access it drives one active-low region select, a read strobe for the memories, and one of two cycle-termination signals. The normal acknowledge ends ordinary cycles and can be held off by an external wait line. The synchronous-peripheral request ends slow-I/O cycles.

After reset a boot overlay flag is set. While it is set, the second-highest address bit is treated as one during decoding, so the processor fetches its reset stack pointer and program counter from ROM. The first completed slow-I/O cycle clears the flag, and from then on RAM answers at address zero, where the vector table can be rewritten. An interrupt acknowledge cycle drives the upper address lines high. That address decodes as slow I/O, so the peripheral request answers it and the processor takes an autovector.

Top module: `boot_bus_glue`

## Requirements
- R1: With the overlay clear and `as_n` low, the region code {addr[19], addr[18]} selects the region: 2'b00 RAM, 2'b01 ROM, 2'b10 fast I/O, 2'b11 slow I/O. Exactly the matching select is driven low.
- R2: After reset the overlay is set. The decoder then uses addr[18] = 1, so 0x00000 and 0x00004 select ROM and 0x80000 selects slow I/O.
- R3: The overlay stays set across any number of RAM-region and ROM-region accesses.
- R4: The overlay clears at the first clock edge that sees `as_n` high after a cycle that decoded as slow I/O. The next access to 0x00000 selects RAM. An asynchronous low on `rst_n` sets the overlay again.
- R5: `rd_n` is always the logical inverse of `wr_n`.
- R6: `ack_n` is low exactly when `as_n` is low, `wait_n` is high and the access is not slow I/O. A low `wait_n` holds it high, which stretches RAM, ROM and fast-I/O cycles.
- R7: `sync_req_n` is low exactly when `as_n` is low and the access decodes as slow I/O. `ack_n` and `sync_req_n` are never low together.
- R8: While `as_n` is high, all four selects, `ack_n` and `sync_req_n` are high. At no time is more than one select low.
- R9: An interrupt acknowledge cycle (address 0xFFFFF) drives `sync_req_n` low and keeps `ack_n` high.
- R10: `offset` equals addr[17:0] in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overlay flag |
| rst_n | input | 1 | Asynchronous active-low reset; sets the overlay |
| addr | input | 20 | Processor address |
| as_n | input | 1 | Active-low address strobe |
| wr_n | input | 1 | Active-low write strobe |
| wait_n | input | 1 | Active-low external wait request |
| ram_sel_n | output | 1 | RAM region select |
| rom_sel_n | output | 1 | ROM region select |
| fio_sel_n | output | 1 | Fast-I/O region select |
| sio_sel_n | output | 1 | Slow-I/O region select |
| rd_n | output | 1 | Active-low read strobe / memory output enable |
| ack_n | output | 1 | Active-low normal cycle acknowledge |
| sync_req_n | output | 1 | Active-low synchronous-peripheral request |
| offset | output | 18 | In-region byte offset |

## Verification
On every cycle the assertions check several properties. The selects are one-hot or idle. All outputs are released while the strobe is high. The two terminations are never active together. A wait request always blocks the acknowledge. The all-ones address always produces the peripheral request. ROM is always selected for its own region code. The overlay cannot be seen cycle by cycle, because it only shows up as a region change across accesses. The bench's scenarios show it: the reset-vector fetch, repeated RAM/ROM accesses that leave address zero on ROM, the single slow-I/O access that moves address zero to RAM, and a reset that puts it back. The bench also exercises the wait-stretched fast-I/O cycle. The behavioural reference model compares every output on every clock.

// File: rtl/boot_bus_glue.sv
module boot_bus_glue #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              wr_n,
  input  logic              wait_n,
  output logic              ram_sel_n,
  output logic              rom_sel_n,
  output logic              fio_sel_n,
  output logic              sio_sel_n,
  output logic              rd_n,
  output logic              ack_n,
  output logic              sync_req_n,
  output logic [ADDR_W-3:0] offset
);

  localparam int HI = ADDR_W - 1;
  localparam int MID = ADDR_W - 2;

  logic       boot_q;
  logic       as_q;
  logic       sio_hit_q;
  logic [1:0] region;
  logic [3:0] hit;

  assign region = {addr[HI], addr[MID] | boot_q};

  always_comb begin
    hit = 4'b0000;
    if (!as_n) hit[region] = 1'b1;
  end

  assign ram_sel_n  = ~hit[0];
  assign rom_sel_n  = ~hit[1];
  assign fio_sel_n  = ~hit[2];
  assign sio_sel_n  = ~hit[3];
  assign sync_req_n = sio_sel_n;
  assign ack_n      = ~(~as_n & wait_n & sio_sel_n);
  assign rd_n       = ~wr_n;
  assign offset     = addr[MID-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q    <= 1'b1;
      as_q      <= 1'b1;
      sio_hit_q <= 1'b0;
    end else begin
      as_q <= as_n;
      if (!as_n) begin
        sio_hit_q <= sio_hit_q | hit[3];
      end else begin
        if (!as_q && sio_hit_q) boot_q <= 1'b0;
        sio_hit_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/boot_bus_glue_chk.sv
module boot_bus_glue_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              as_n,
  input logic              wait_n,
  input logic              ram_sel_n,
  input logic              rom_sel_n,
  input logic              fio_sel_n,
  input logic              sio_sel_n,
  input logic              ack_n,
  input logic              sync_req_n
);

  logic [3:0] sels;
  assign sels = {~sio_sel_n, ~fio_sel_n, ~rom_sel_n, ~ram_sel_n};

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (sels == 4'b0000 && ack_n && sync_req_n));

  assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels));

  assert_single_termination_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ack_n && !sync_req_n));

  assert_wait_blocks_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |-> ack_n);

  assert_intack_autovector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && &addr) |-> (!sync_req_n && ack_n));

  assert_rom_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && addr[ADDR_W-1:ADDR_W-2] == 2'b01) |-> !rom_sel_n);

endmodule

bind boot_bus_glue boot_bus_glue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .wait_n(wait_n),
  .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .fio_sel_n(fio_sel_n),
  .sio_sel_n(sio_sel_n), .ack_n(ack_n), .sync_req_n(sync_req_n)
);

// File: tb/boot_bus_glue_tb.sv
module boot_bus_glue_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        as_n = 1'b1, wr_n = 1'b1, wait_n = 1'b1;
  logic        ram_sel_n, rom_sel_n, fio_sel_n, sio_sel_n, rd_n, ack_n, sync_req_n;
  logic [17:0] offset;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_bus_glue u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .wr_n(wr_n),
    .wait_n(wait_n), .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n),
    .fio_sel_n(fio_sel_n), .sio_sel_n(sio_sel_n), .rd_n(rd_n),
    .ack_n(ack_n), .sync_req_n(sync_req_n), .offset(offset)
  );

  // Behavioural reference model
  bit m_boot = 1, m_pend = 0;

  function automatic int exp_region();
    int r;
    r = (addr[19] ? 2 : 0) + ((addr[18] || m_boot) ? 1 : 0);
    return r;
  endfunction

  function automatic bit exp_sel_n(int idx);
    return !(as_n == 1'b0 && exp_region() == idx);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_boot <= 1; m_pend <= 0;
    end else if (!as_n) begin
      if (exp_region() == 3) m_pend <= 1;
    end else if (m_pend) begin
      m_boot <= 0; m_pend <= 0;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1", "ram_sel_n", ram_sel_n, exp_sel_n(0));
    chk("R1", "rom_sel_n", rom_sel_n, exp_sel_n(1));
    chk("R1", "fio_sel_n", fio_sel_n, exp_sel_n(2));
    chk("R1", "sio_sel_n", sio_sel_n, exp_sel_n(3));
    chk("R5", "rd_n", rd_n, !wr_n);
    chk("R6", "ack_n", ack_n, !(as_n == 0 && wait_n && exp_region() != 3));
    chk("R7", "sync_req_n", sync_req_n, exp_sel_n(3));
    chk("R10", "offset", offset, addr[17:0]);
  end

  task automatic start_cycle(logic [19:0] a, bit wr);
    @(posedge clk); #1;
    addr = a; wr_n = !wr; as_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_cycle();
    @(posedge clk); #1;
    as_n = 1'b1; wr_n = 1'b1; wait_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // reset state, R8
    #(CLK_PERIOD * 2);
    chk("R8", "ram_sel_n at reset", ram_sel_n, 1);
    chk("R8", "sync_req_n at reset", sync_req_n, 1);
    chk("R8", "ack_n at reset", ack_n, 1);
    @(negedge clk); rst_n = 1'b1;

    // R2 reset vector fetch from ROM
    start_cycle(20'h00000, 0);
    chk("R2", "rom_sel_n @0", rom_sel_n, 0);
    chk("R2", "ram_sel_n @0", ram_sel_n, 1);
    chk("R5", "rd_n on read", rd_n, 0);
    end_cycle();
    start_cycle(20'h00004, 0);
    chk("R2", "rom_sel_n @4", rom_sel_n, 0);
    end_cycle();

    // R3 overlay survives RAM/ROM traffic, writes included
    for (int i = 0; i < 6; i++) begin
      start_cycle(20'h40000 + 20'(i * 16), i[0]);
      end_cycle();
      start_cycle(20'h00100 + 20'(i), i[0]);
      chk("R3", "rom_sel_n low-region during boot", rom_sel_n, 0);
      if (i[0]) chk("R5", "rd_n on write", rd_n, 1);
      end_cycle();
    end
    start_cycle(20'h00000, 0);
    chk("R3", "rom_sel_n @0 after traffic", rom_sel_n, 0);
    end_cycle();

    // R2 fast-I/O address decodes as slow I/O during boot
    start_cycle(20'h80000, 0);
    chk("R2", "sio_sel_n @80000 in boot", sio_sel_n, 0);
    chk("R7", "ack_n in slow cycle", ack_n, 1);
    chk("R7", "sync_req_n in slow cycle", sync_req_n, 0);
    end_cycle();

    // R4 RAM now at zero
    start_cycle(20'h00000, 0);
    chk("R4", "ram_sel_n @0 after slow I/O", ram_sel_n, 0);
    chk("R4", "rom_sel_n @0 after slow I/O", rom_sel_n, 1);
    end_cycle();

    // R1 all four regions
    start_cycle(20'h40123, 0); chk("R1", "rom_sel_n", rom_sel_n, 0); end_cycle();
    start_cycle(20'h3FFFF, 1); chk("R1", "ram_sel_n", ram_sel_n, 0); end_cycle();
    start_cycle(20'h80042, 0); chk("R1", "fio_sel_n", fio_sel_n, 0);
    chk("R10", "offset", offset, 18'h00042); end_cycle();
    start_cycle(20'hC0007, 1); chk("R1", "sio_sel_n", sio_sel_n, 0); end_cycle();

    // R6 wait-stretched fast-I/O cycle
    start_cycle(20'h80010, 0);
    wait_n = 1'b0;
    #1;
    chk("R6", "ack_n held by wait", ack_n, 1);
    repeat (3) @(negedge clk);
    chk("R6", "ack_n still held", ack_n, 1);
    chk("R6", "fio_sel_n during wait", fio_sel_n, 0);
    wait_n = 1'b1;
    @(negedge clk);
    chk("R6", "ack_n after wait", ack_n, 0);
    end_cycle();
    @(negedge clk);
    chk("R8", "ack_n idle", ack_n, 1);
    chk("R8", "fio_sel_n idle", fio_sel_n, 1);

    // R9 interrupt acknowledge
    start_cycle(20'hFFFFF, 0);
    chk("R9", "sync_req_n intack", sync_req_n, 0);
    chk("R9", "ack_n intack", ack_n, 1);
    end_cycle();

    // R4 reset re-arms overlay
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    start_cycle(20'h00000, 0);
    chk("R4", "rom_sel_n @0 after re-reset", rom_sel_n, 0);
    end_cycle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule